// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into the stream of column addresses a double-data-rate DRAM array model needs for a read or write burst. A mode-load strobe sets three fields: read latency, burst length and burst order. A start pulse with a starting column then launches a burst. From the next cycle on, the block presents one column address per clock until the burst runs out or a terminate input stops it. A full-page burst wraps around the 256-column page and keeps running until it is terminated. Illegal mode loads and illegal start requests are refused and flagged, and the refused request has no effect. The row path, data capture, refresh and the electrical interface belong to other blocks.

A controller state machine has three states. ST_IDLE waits for a start. A start goes to ST_BURST when it is legal and to ST_REJECT when it is a full-page start on an odd column. ST_BURST returns to ST_IDLE after the final beat of a fixed-length burst, or in any cycle where terminate is sampled high. ST_REJECT always returns to ST_IDLE after one cycle. The mode fields are captured when a burst launches, so a mode load during a burst only applies to the next burst. The read latency is held and brought out on its own port for the data path.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, col_valid, col_last, start_err and mode_err are low and the mode is latency 3, 2-beat length, sequential order.
- R2: A legal mode load (mrs_valid high) takes effect at the clock edge that samples it. mrs_latency is the binary clock count 3, 4 or 5. mrs_blen is coded 1 = 2 beats, 2 = 4 beats, 3 = 8 beats, 7 = full page. mrs_btype is 0 for sequential and 1 for interleaved. rd_latency shows the loaded latency from the next cycle.
- R3: A mode load is illegal if it has a latency outside 3..5, a length code not in {1,2,3,7}, or full page with interleaved order. An illegal load leaves every mode field unchanged and raises mode_err for exactly the one cycle after it.
- R4: A start sampled in ST_IDLE puts the first column on col_addr with col_valid high in the next cycle, followed by one new column per cycle. A start sampled in ST_REJECT is ignored.
- R5: A sequential burst of length L from start column S gives, at beat i, the column whose bits above log2(L) equal those of S and whose low bits equal (S mod L + i) mod L.
- R6: An interleaved burst of length L gives, at beat i, S with its low log2(L) bits XORed with i.
- R7: A full-page burst gives (S + i) mod 256 at beat i and continues past 256 beats until terminated.
- R8: A full-page start on an odd column gives no burst and raises start_err for exactly the one cycle after the start.
- R9: col_last is high only on the final beat of a 2, 4 or 8 beat burst, never in full-page mode, and col_valid is low in the cycle after it.
- R10: If terminate is sampled high in a burst cycle, that cycle's column is the last one shown and col_valid is low in the next cycle.
- R11: A start during a burst is ignored. A mode load during a burst does not change the running burst, but it applies to the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mrs_valid | input | 1 | Mode load strobe |
| mrs_latency | input | 3 | Read latency in clocks |
| mrs_blen | input | 3 | Burst length code |
| mrs_btype | input | 1 | Burst order: 0 sequential, 1 interleaved |
| start | input | 1 | Burst start pulse |
| start_col | input | 8 | Starting column |
| terminate | input | 1 | Ends the running burst after the current column |
| col_valid | output | 1 | col_addr carries a burst column |
| col_addr | output | 8 | Current column address |
| col_last | output | 1 | Final beat of a fixed-length burst |
| start_err | output | 1 | One-cycle flag for a refused start |
| mode_err | output | 1 | One-cycle flag for a refused mode load |
| rd_latency | output | 3 | Held read latency |

## Verification
The hardest case to reach is the full-page wrap. The column must pass 255 and return to 0 while the burst stays open. This only shows after about 256 beats with terminate held off, so one burst starts at column 250 and is only terminated after 300 beats. The other hard case is a mode load or a second start that lands in the middle of a burst. The stimulus pulses both while an 8-beat burst is running. The scoreboard still expects the original sequence, and the next burst is expected to follow the new mode.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    parameter int COL_W = 8;
    parameter int LAT_W = 3;

    localparam logic [2:0] BLC_2  = 3'd1;
    localparam logic [2:0] BLC_4  = 3'd2;
    localparam logic [2:0] BLC_8  = 3'd3;
    localparam logic [2:0] BLC_FP = 3'd7;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } border_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BURST  = 2'd1,
        ST_REJECT = 2'd2
    } sq_state_e;

    typedef struct packed {
        logic [LAT_W-1:0] lat;
        logic [2:0]       blen;
        border_e          order;
    } mode_t;

    function automatic logic blen_code_ok(input logic [2:0] code);
        return (code == BLC_2) || (code == BLC_4) || (code == BLC_8) || (code == BLC_FP);
    endfunction

    // Wrap mask of the low column bits that move within one burst.
    function automatic logic [COL_W-1:0] wrap_mask(input logic [2:0] code);
        logic [COL_W-1:0] m;
        case (code)
            BLC_2:   m = COL_W'(1);
            BLC_4:   m = COL_W'(3);
            BLC_8:   m = COL_W'(7);
            BLC_FP:  m = {COL_W{1'b1}};
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bseq_mode_reg.sv
module bseq_mode_reg
    import burst_seq_pkg::*;
#(
    parameter int LAT_MIN = 3,
    parameter int LAT_MAX = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mrs_valid,
    input  logic [LAT_W-1:0] lat_in,
    input  logic [2:0]       blen_in,
    input  logic             order_in,
    output mode_t            mode_q,
    output logic             mode_err
);

    logic lat_ok;
    logic combo_ok;
    logic load_ok;

    always_comb begin
        lat_ok   = (int'(lat_in) >= LAT_MIN) && (int'(lat_in) <= LAT_MAX);
        combo_ok = !((blen_in == BLC_FP) && (order_in == 1'b1));
        load_ok  = lat_ok && blen_code_ok(blen_in) && combo_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q.lat   <= LAT_W'(LAT_MIN);
            mode_q.blen  <= BLC_2;
            mode_q.order <= ORD_SEQ;
            mode_err     <= 1'b0;
        end else begin
            mode_err <= mrs_valid && !load_ok;
            if (mrs_valid && load_ok) begin
                mode_q.lat   <= lat_in;
                mode_q.blen  <= blen_in;
                mode_q.order <= border_e'(order_in);
            end
        end
    end

    p_lat_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(mode_q.lat) >= LAT_MIN) && (int'(mode_q.lat) <= LAT_MAX));

    p_bad_load_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> $stable(mode_q));

endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
    import burst_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             terminate,
    input  logic [2:0]       cfg_blen,
    input  border_e          cfg_order,
    output logic             col_valid,
    output logic             col_last,
    output logic             start_err,
    output logic [COL_W-1:0] run_base,
    output logic [COL_W-1:0] run_beat,
    output logic [2:0]       run_blen,
    output border_e          run_order
);

    sq_state_e state_q, state_d;
    logic      fp_odd;
    logic      run_fp;
    logic      beat_last;
    logic      launch;

    always_comb begin
        fp_odd    = (cfg_blen == BLC_FP) && start_col[0];
        run_fp    = (run_blen == BLC_FP);
        beat_last = !run_fp && (run_beat == wrap_mask(run_blen));
        launch    = (state_q == ST_IDLE) && start && !fp_odd;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = fp_odd ? ST_REJECT : ST_BURST;
            ST_BURST:  if (terminate || beat_last) state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        col_valid = (state_q == ST_BURST);
        col_last  = col_valid && beat_last;
        start_err = (state_q == ST_REJECT);
    end

    // burst context captured at launch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_base  <= '0;
            run_beat  <= '0;
            run_blen  <= BLC_2;
            run_order <= ORD_SEQ;
        end else if (launch) begin
            run_base  <= start_col;
            run_beat  <= '0;
            run_blen  <= cfg_blen;
            run_order <= cfg_order;
        end else if (state_q == ST_BURST) begin
            run_beat  <= run_beat + 1'b1;
        end
    end

    p_launch_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_valid) |-> $past(start));

    p_reject_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_err) |-> ($past(start) && $past(cfg_blen == BLC_FP) && $past(start_col[0])));

    p_fp_even_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && run_fp) |-> !run_base[0]);

    p_last_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |=> !col_valid);

endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen
    import burst_seq_pkg::*;
(
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [2:0]       blen,
    input  border_e          order,
    output logic [COL_W-1:0] addr
);

    logic [COL_W-1:0] seq_val;
    logic [COL_W-1:0] ilv_val;
    logic [COL_W-1:0] moving;

    always_comb begin
        seq_val = base + beat;
        ilv_val = base ^ beat;
        moving  = wrap_mask(blen);
    end

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign addr[b] = moving[b] ? ((order == ORD_ILV) ? ilv_val[b] : seq_val[b]) : base[b];
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int LAT_MIN = 3,
    parameter int LAT_MAX = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mrs_valid,
    input  logic [LAT_W-1:0] mrs_latency,
    input  logic [2:0]       mrs_blen,
    input  logic             mrs_btype,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             terminate,
    output logic             col_valid,
    output logic [COL_W-1:0] col_addr,
    output logic             col_last,
    output logic             start_err,
    output logic             mode_err,
    output logic [LAT_W-1:0] rd_latency
);

    mode_t            mode_q;
    logic [COL_W-1:0] run_base;
    logic [COL_W-1:0] run_beat;
    logic [2:0]       run_blen;
    border_e          run_order;

    bseq_mode_reg #(
        .LAT_MIN (LAT_MIN),
        .LAT_MAX (LAT_MAX)
    ) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mrs_valid(mrs_valid),
        .lat_in   (mrs_latency),
        .blen_in  (mrs_blen),
        .order_in (mrs_btype),
        .mode_q   (mode_q),
        .mode_err (mode_err)
    );

    bseq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .start_col(start_col),
        .terminate(terminate),
        .cfg_blen (mode_q.blen),
        .cfg_order(mode_q.order),
        .col_valid(col_valid),
        .col_last (col_last),
        .start_err(start_err),
        .run_base (run_base),
        .run_beat (run_beat),
        .run_blen (run_blen),
        .run_order(run_order)
    );

    bseq_addr_gen u_addr (
        .base (run_base),
        .beat (run_beat),
        .blen (run_blen),
        .order(run_order),
        .addr (col_addr)
    );

    assign rd_latency = mode_q.lat;

    p_addr_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && $past(col_valid)) |-> (col_addr != $past(col_addr)));

endmodule

// File: tb/burst_col_seq_bench.sv
`timescale 1ns/1ps
module burst_col_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mrs_valid = 1'b0;
    logic [2:0] mrs_latency = 3'd3;
    logic [2:0] mrs_blen = 3'd1;
    logic       mrs_btype = 1'b0;
    logic       start = 1'b0;
    logic [7:0] start_col = 8'd0;
    logic       terminate = 1'b0;
    logic       col_valid;
    logic [7:0] col_addr;
    logic       col_last;
    logic       start_err;
    logic       mode_err;
    logic [2:0] rd_latency;

    int checks = 0;
    int errors = 0;
    logic [8:0] exp_q[$];
    string cur_req = "R1";

    int m_lat = 3;
    int m_code = 1;
    int m_ilv = 0;

    always #2.5 clk = ~clk;

    burst_col_seq u_burst_col_seq (
        .clk(clk), .rst_n(rst_n), .mrs_valid(mrs_valid), .mrs_latency(mrs_latency),
        .mrs_blen(mrs_blen), .mrs_btype(mrs_btype), .start(start), .start_col(start_col),
        .terminate(terminate), .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last),
        .start_err(start_err), .mode_err(mode_err), .rd_latency(rd_latency)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int code_len(input int code);
        case (code)
            1: return 2;
            2: return 4;
            3: return 8;
            default: return 256;
        endcase
    endfunction

    // Reference column for beat i
    function automatic int ref_col(input int s, input int i);
        int len, blk, off;
        len = code_len(m_code);
        if (m_code == 7) return (s + i) % 256;
        blk = s - (s % len);
        off = s % len;
        if (m_ilv != 0) return blk + (off ^ (i % len));
        return blk + ((off + i) % len);
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && col_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, {cur_req, " unexpected column"}, int'(col_addr), -1);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check(col_addr == e[7:0], {cur_req, " column"}, int'(col_addr), int'(e[7:0]));
                check(col_last == e[8], "R9 last flag", int'(col_last), int'(e[8]));
            end
        end
    end

    task automatic do_mrs(input int lat, input int code, input int ilv, input bit legal, input string req);
        @(negedge clk);
        mrs_valid = 1'b1; mrs_latency = 3'(lat); mrs_blen = 3'(code); mrs_btype = ilv[0];
        @(negedge clk);
        mrs_valid = 1'b0;
        if (legal) begin
            m_lat = lat; m_code = code; m_ilv = ilv;
        end
        check(mode_err == !legal, {req, " mode_err"}, int'(mode_err), int'(!legal));
        check(int'(rd_latency) == m_lat, {req, " rd_latency"}, int'(rd_latency), m_lat);
        @(negedge clk);
        check(mode_err == 1'b0, {req, " mode_err one cycle"}, int'(mode_err), 0);
    endtask

    // term_after = 0: no terminate; otherwise terminate on beat term_after-1
    task automatic do_burst(input int s, input int term_after, input string req);
        int len, n;
        len = code_len(m_code);
        if (m_code == 7) n = term_after;
        else n = (term_after > 0 && term_after < len) ? term_after : len;
        cur_req = req;
        for (int i = 0; i < n; i++) begin
            logic lst;
            lst = (m_code != 7) && (i == len - 1);
            exp_q.push_back({lst, 8'(ref_col(s, i))});
        end
        @(negedge clk);
        start = 1'b1; start_col = 8'(s);
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j < n; j++) begin
            terminate = (term_after > 0) && (j == term_after - 1);
            @(negedge clk);
            terminate = 1'b0;
        end
        check(col_valid == 1'b0, {req, " burst closed"}, int'(col_valid), 0);
        check(exp_q.size() == 0, {req, " all columns seen"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (200000 - 100) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(col_valid == 0, "R1 col_valid", int'(col_valid), 0);
        check(col_last == 0, "R1 col_last", int'(col_last), 0);
        check(start_err == 0, "R1 start_err", int'(start_err), 0);
        check(mode_err == 0, "R1 mode_err", int'(mode_err), 0);
        check(rd_latency == 3'd3, "R1 rd_latency", int'(rd_latency), 3);
        do_burst(5, 0, "R1 default BL2 seq");

        // R2 legal loads
        do_mrs(4, 2, 0, 1'b1, "R2");
        do_mrs(5, 3, 1, 1'b1, "R2");
        do_burst(13, 0, "R2 new mode used");

        // R3 illegal loads, mode kept (8-beat interleaved)
        do_mrs(2, 1, 0, 1'b0, "R3 latency low");
        do_mrs(6, 1, 0, 1'b0, "R3 latency high");
        do_mrs(3, 0, 0, 1'b0, "R3 length code 0");
        do_mrs(3, 4, 0, 1'b0, "R3 length code 4");
        do_mrs(3, 7, 1, 1'b0, "R3 full page interleaved");
        do_burst(10, 0, "R3 old mode kept");

        // R5/R6/R4 all fixed lengths, both orders, every start
        for (int bt = 0; bt < 2; bt++) begin
            for (int c = 1; c <= 3; c++) begin
                do_mrs(3, c, bt, 1'b1, "R2");
                for (int s = 0; s < 256; s++)
                    do_burst(s, 0, bt ? "R6 interleaved" : "R5 sequential");
            end
        end

        // R10 terminate inside a fixed burst
        do_mrs(3, 3, 1, 1'b1, "R2");
        do_burst(13, 3, "R10 terminate fixed");

        // R11 start and mode load during a burst
        do_mrs(4, 3, 0, 1'b1, "R2");
        cur_req = "R11 busy";
        for (int i = 0; i < 8; i++) exp_q.push_back({(i == 7), 8'(ref_col(20, i))});
        @(negedge clk); start = 1'b1; start_col = 8'd20;
        @(negedge clk); start = 1'b0;
        for (int j = 0; j < 8; j++) begin
            if (j == 2) begin start = 1'b1; start_col = 8'd99; end
            if (j == 4) begin mrs_valid = 1'b1; mrs_latency = 3'd5; mrs_blen = 3'd1; mrs_btype = 1'b1; end
            @(negedge clk);
            start = 1'b0; mrs_valid = 1'b0;
        end
        check(col_valid == 0, "R11 burst closed", int'(col_valid), 0);
        check(exp_q.size() == 0, "R11 all columns seen", exp_q.size(), 0);
        exp_q.delete();
        repeat (2) @(negedge clk);
        check(col_valid == 0, "R11 ignored start gave no burst", int'(col_valid), 0);
        m_lat = 5; m_code = 1; m_ilv = 1;
        check(rd_latency == 3'd5, "R11 load applied", int'(rd_latency), 5);
        do_burst(7, 0, "R11 next burst new mode");

        // R7 full page every even start, R8 odd starts refused
        do_mrs(3, 7, 0, 1'b1, "R2");
        for (int s = 0; s < 256; s += 2) do_burst(s, 3, "R7 full page");
        do_burst(250, 300, "R7 full page wrap");
        for (int s = 1; s < 256; s += 64) begin
            cur_req = "R8 odd start";
            @(negedge clk); start = 1'b1; start_col = 8'(s);
            @(negedge clk); start = 1'b0;
            check(start_err == 1, "R8 start_err", int'(start_err), 1);
            check(col_valid == 0, "R8 no burst", int'(col_valid), 0);
            // R4: start while in reject state is ignored
            start = 1'b1; start_col = 8'd2;
            @(negedge clk); start = 1'b0;
            check(start_err == 0, "R8 start_err one cycle", int'(start_err), 0);
            check(col_valid == 0, "R4 start in reject ignored", int'(col_valid), 0);
            @(negedge clk);
            check(col_valid == 0, "R4 still idle", int'(col_valid), 0);
        end

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule